// File: doc/BRIEF.md
# Flag Offset Programming Sequencer

This block stores the two thresholds that a FIFO's flag logic compares against. The almost-empty threshold sits in one 12-bit register and the almost-full threshold in another. Software or a controller programs them through the FIFO's own data input and reads them back through the FIFO's data output, using an active-low load pin. The registers have no address. A one-bit selection pointer on the write clock and a second one on the read clock each step through the pair, empty threshold first and full threshold next, then wrap around. Each pointer keeps its position across load episodes.

The block also decodes the load pin together with each side's active-low enable. From them it decides whether a clock edge is a normal FIFO access, which is reported on a strobe for the storage array, an offset access, or nothing. Reset puts a default into both thresholds. The default depends on the FIFO depth. The FIFO array and the flag comparators sit outside this block.

Top module: `offset_seq`

## Requirements
- R1: A clock edge with reset high sets both thresholds to the default (31 for depth 256 or less, 63 for 512, 127 for larger depths). The same edge returns both selection pointers to the empty threshold and clears the readback register to zero.
- R2: Each write-clock edge with load_n low and wr_en_n low stores din[11:0] into the currently selected threshold. The write pointer then advances in the order empty, full, empty. din bits above 11 are ignored.
- R3: A write-clock edge with load_n low and wr_en_n high changes neither threshold nor the write selection pointer.
- R4: fifo_wr_o is 1 exactly when load_n is high and wr_en_n is low. fifo_rd_o is 1 exactly when load_n is high and rd_en_n is low. An offset access never raises either strobe.
- R5: If load_n is raised after only one threshold has been written, the next offset write goes to the other threshold; the sequence does not restart.
- R6: Each read-clock edge with load_n low and rd_en_n low loads the selected threshold into q_o, zero-extended so that q_o bits above 11 read 0. The read pointer then advances in the order empty, full, empty.
- R7: The read pointer moves only on offset reads and the write pointer only on offset writes; neither disturbs the other.
- R8: When a read-clock edge is not an offset read, q_o and the read pointer hold their values, including during normal FIFO reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| load_n | input | 1 | Active-low selection of offset access |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| din | input | DATA_W | FIFO data input; bits 11..0 carry a threshold |
| fifo_wr_o | output | 1 | Normal FIFO write strobe for the array |
| fifo_rd_o | output | 1 | Normal FIFO read strobe for the array |
| empty_off_o | output | 12 | Almost-empty threshold for the flag logic |
| full_off_o | output | 12 | Almost-full threshold for the flag logic |
| q_o | output | DATA_W | Offset readback register |

## Verification
The bench writes three thresholds in a row. That shows whether the pointer wraps to the empty threshold or sticks on the full one. Idle load cycles with the write enable high, followed by one further write, show whether a disabled edge leaks into the pointer. A split programming episode, with normal FIFO writes between two single offset writes, separates a sequence that continues from one that restarts on each load episode. The readback passes are placed so that the write pointer and the read pointer stand at different positions, and they are mixed with read-enable-high cycles and normal reads. These passes expose shared pointers, readback that drops the zero fill, and a q_o register that does not hold.

// File: rtl/offset_pkg.sv
package offset_pkg;

    localparam int OFFSET_W = 12;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } off_sel_e;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_FIFO   = 2'd1,
        ACC_OFFSET = 2'd2
    } access_e;

    typedef struct packed {
        logic [OFFSET_W-1:0] empty_off;
        logic [OFFSET_W-1:0] full_off;
    } offset_pair_t;

    function automatic int default_offset(input int depth);
        if (depth <= 256)
            return 31;
        else if (depth <= 512)
            return 63;
        else
            return 127;
    endfunction

    function automatic access_e decode_access(input logic load_n, input logic en_n);
        if (en_n)
            return ACC_NONE;
        else if (!load_n)
            return ACC_OFFSET;
        else
            return ACC_FIFO;
    endfunction

    function automatic off_sel_e next_sel(input off_sel_e cur);
        return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

endpackage

// File: rtl/offset_access_decode.sv
module offset_access_decode
    import offset_pkg::*;
(
    input  logic load_n,
    input  logic en_n,
    output logic fifo_op,
    output logic off_op
);
    access_e acc;

    always_comb begin
        acc     = decode_access(load_n, en_n);
        fifo_op = (acc == ACC_FIFO);
        off_op  = (acc == ACC_OFFSET);
    end
endmodule

// File: rtl/offset_write_bank.sv
module offset_write_bank
    import offset_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              off_wr,
    input  logic [DATA_W-1:0] din,
    output offset_pair_t      regs,
    output off_sel_e          wsel
);
    localparam logic [OFFSET_W-1:0] DFLT = OFFSET_W'(default_offset(DEPTH));

    logic [OFFSET_W-1:0] wdata;
    assign wdata = din[OFFSET_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.empty_off <= DFLT;
            regs.full_off  <= DFLT;
            wsel           <= SEL_EMPTY;
        end else if (off_wr) begin
            if (wsel == SEL_EMPTY)
                regs.empty_off <= wdata;
            else
                regs.full_off  <= wdata;
            wsel <= next_sel(wsel);
        end
    end

    // R1: reset loads defaults and points at the empty threshold
    assert_reset_defaults_R1: assert property (@(posedge clk)
        rst |=> (regs.empty_off == DFLT && regs.full_off == DFLT && wsel == SEL_EMPTY));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !off_wr |=> ($stable(regs) && $stable(wsel)));

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
        off_wr |=> (wsel != $past(wsel)));

    assert_empty_target_R2: assert property (@(posedge clk) disable iff (rst)
        (off_wr && wsel == SEL_EMPTY) |=>
            (regs.empty_off == $past(din[OFFSET_W-1:0]) && $stable(regs.full_off)));

    assert_full_target_R2: assert property (@(posedge clk) disable iff (rst)
        (off_wr && wsel == SEL_FULL) |=>
            (regs.full_off == $past(din[OFFSET_W-1:0]) && $stable(regs.empty_off)));
endmodule

// File: rtl/offset_readback.sv
module offset_readback
    import offset_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              off_rd,
    input  offset_pair_t      regs,
    output logic [DATA_W-1:0] q,
    output off_sel_e          rsel
);
    logic [OFFSET_W-1:0] picked;

    always_comb begin
        picked = (rsel == SEL_EMPTY) ? regs.empty_off : regs.full_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            rsel <= SEL_EMPTY;
        end else if (off_rd) begin
            q    <= DATA_W'(picked);
            rsel <= next_sel(rsel);
        end
    end

    assert_readback_reset_R1: assert property (@(posedge clk)
        rst |=> (q == '0 && rsel == SEL_EMPTY));

    assert_readback_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !off_rd |=> ($stable(q) && $stable(rsel)));

    assert_read_ptr_advance_R7: assert property (@(posedge clk) disable iff (rst)
        off_rd |=> (rsel != $past(rsel)));

    generate
        if (DATA_W > OFFSET_W) begin : g_upper
            assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
                off_rd |=> (q[DATA_W-1:OFFSET_W] == '0));
        end
    endgenerate
endmodule

// File: rtl/offset_seq.sv
module offset_seq
    import offset_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 256
) (
    input  logic                wr_clk,
    input  logic                rd_clk,
    input  logic                rst,
    input  logic                load_n,
    input  logic                wr_en_n,
    input  logic                rd_en_n,
    input  logic [DATA_W-1:0]   din,
    output logic                fifo_wr_o,
    output logic                fifo_rd_o,
    output logic [OFFSET_W-1:0] empty_off_o,
    output logic [OFFSET_W-1:0] full_off_o,
    output logic [DATA_W-1:0]   q_o
);
    logic         wr_off;
    logic         rd_off;
    offset_pair_t regs;
    off_sel_e     wsel;
    off_sel_e     rsel;

    offset_access_decode u_wdec (
        .load_n (load_n),
        .en_n   (wr_en_n),
        .fifo_op(fifo_wr_o),
        .off_op (wr_off)
    );

    offset_access_decode u_rdec (
        .load_n (load_n),
        .en_n   (rd_en_n),
        .fifo_op(fifo_rd_o),
        .off_op (rd_off)
    );

    offset_write_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
        .clk   (wr_clk),
        .rst   (rst),
        .off_wr(wr_off),
        .din   (din),
        .regs  (regs),
        .wsel  (wsel)
    );

    offset_readback #(.DATA_W(DATA_W)) u_rb (
        .clk   (rd_clk),
        .rst   (rd_rst_unused_guard(rst)),
        .off_rd(rd_off),
        .regs  (regs),
        .q     (q_o),
        .rsel  (rsel)
    );

    function automatic logic rd_rst_unused_guard(input logic r);
        return r;
    endfunction

    assign empty_off_o = regs.empty_off;
    assign full_off_o  = regs.full_off;

    assert_wr_exclusive_R4: assert property (@(posedge wr_clk) disable iff (rst)
        $onehot0({fifo_wr_o, wr_off}));

    assert_rd_exclusive_R4: assert property (@(posedge rd_clk) disable iff (rst)
        $onehot0({fifo_rd_o, rd_off}));

    // R7: an offset write leaves the read pointer where it was
    assert_rsel_untouched_R7: assert property (@(posedge wr_clk) disable iff (rst)
        (wr_off && rd_en_n) |=> $stable(rsel));
endmodule

// File: tb/offset_seq_tb_top.sv
module offset_seq_tb_top;
    localparam int DW = 18;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_n = 1'b1;
    logic          wr_en_n = 1'b1;
    logic          rd_en_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic          fifo_wr_o, fifo_rd_o;
    logic [11:0]   empty_off_o, full_off_o;
    logic [DW-1:0] q_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag = "R1";

    // behavioural reference state
    logic [11:0]   m_off[2];
    int            m_wsel = 0;
    int            m_rsel = 0;
    logic [DW-1:0] m_q = '0;
    logic          m_fwr, m_frd;

    offset_seq #(.DATA_W(DW), .DEPTH(256)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
        .load_n(load_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .din(din),
        .fifo_wr_o(fifo_wr_o), .fifo_rd_o(fifo_rd_o),
        .empty_off_o(empty_off_o), .full_off_o(full_off_o), .q_o(q_o)
    );

    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #1.25;
        forever #2.5 rd_clk = ~rd_clk;
    end

    task automatic chk(input string t, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", t, what, got, exp);
        end
    endtask

    always @(posedge wr_clk) begin
        m_fwr = load_n && !wr_en_n;
        if (!load_n && !wr_en_n && !rd_en_n) begin
            n_fail++;
            $display("FAIL protocol: offset read and write requested together");
        end
        if (rst) begin
            m_off[0] = 12'd31;
            m_off[1] = 12'd31;
            m_wsel   = 0;
        end else if (!load_n && !wr_en_n) begin
            m_off[m_wsel] = din[11:0];
            m_wsel        = 1 - m_wsel;
        end
        #1;
        chk(tag, "fifo_wr_o", 32'(fifo_wr_o), 32'(m_fwr));
        chk(tag, "empty_off_o", 32'(empty_off_o), 32'(m_off[0]));
        chk(tag, "full_off_o", 32'(full_off_o), 32'(m_off[1]));
    end

    always @(posedge rd_clk) begin
        m_frd = load_n && !rd_en_n;
        if (rst) begin
            m_rsel = 0;
            m_q    = '0;
        end else if (!load_n && !rd_en_n) begin
            m_q    = DW'(m_off[m_rsel]);
            m_rsel = 1 - m_rsel;
        end
        #1;
        chk(tag, "fifo_rd_o", 32'(fifo_rd_o), 32'(m_frd));
        chk(tag, "q_o", 32'(q_o), 32'(m_q));
    end

    task automatic wcyc(input logic ld, input logic we, input logic [DW-1:0] d);
        @(negedge wr_clk);
        load_n  = ld;
        wr_en_n = we;
        din     = d;
    endtask

    task automatic rcyc(input logic re);
        @(negedge rd_clk);
        rd_en_n = re;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge wr_clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: reset defaults
        repeat (4) @(negedge wr_clk);
        rst = 1'b0;
        wcyc(1, 1, '0);
        chk("R1", "empty default", 32'(empty_off_o), 32'd31);
        chk("R1", "full default", 32'(full_off_o), 32'd31);
        chk("R1", "q after reset", 32'(q_o), 32'd0);

        // R2: three writes wrap back to empty; upper din bits dropped
        tag = "R2";
        wcyc(0, 0, 18'h3F5A5);
        wcyc(0, 0, 18'h00ABC);
        wcyc(0, 0, 18'h2C123);
        wcyc(1, 1, '0);
        chk("R2", "empty after wrap", 32'(empty_off_o), 32'h123);
        chk("R2", "full second write", 32'(full_off_o), 32'hABC);

        // R3: disabled edges with load low leave everything alone
        tag = "R3";
        for (int i = 0; i < 4; i++) wcyc(0, 1, 18'h3FFFF);
        wcyc(0, 0, 18'h00777);
        wcyc(1, 1, '0);
        chk("R3", "pointer kept at full", 32'(full_off_o), 32'h777);
        chk("R3", "empty untouched", 32'(empty_off_o), 32'h123);

        // R4: normal FIFO writes and idle cycles
        tag = "R4";
        for (int i = 0; i < 3; i++) wcyc(1, 0, 18'h00111);
        wcyc(1, 1, 18'h00222);
        wcyc(1, 1, 18'h00333);

        // R5: split programming continues the sequence
        tag = "R5";
        wcyc(0, 0, 18'h00042);
        wcyc(1, 0, 18'h00555);
        wcyc(1, 0, 18'h00666);
        wcyc(0, 0, 18'h00099);
        wcyc(1, 1, '0);
        chk("R5", "empty first episode", 32'(empty_off_o), 32'h042);
        chk("R5", "full second episode", 32'(full_off_o), 32'h099);

        // R6: readback order and zero fill
        tag = "R6";
        wcyc(0, 1, '0);
        wcyc(0, 1, '0);
        rcyc(0);
        rcyc(0);
        rcyc(0);
        rcyc(1);
        chk("R6", "third read wraps to empty", 32'(q_o), 32'h042);

        // R7: an offset write does not move the read pointer
        tag = "R7";
        wcyc(0, 0, 18'h00E0E);
        wcyc(0, 1, '0);
        rcyc(0);
        rcyc(1);
        chk("R7", "read pointer independent", 32'(q_o), 32'h099);

        // R8: hold on disabled read and on normal FIFO reads
        tag = "R8";
        rcyc(1);
        rcyc(1);
        wcyc(1, 1, '0);
        rcyc(0);
        rcyc(0);
        rcyc(1);
        chk("R8", "q held over FIFO reads", 32'(q_o), 32'h099);
        wcyc(0, 1, '0);
        rcyc(1);
        rcyc(0);
        rcyc(1);
        chk("R8", "read after holds is empty", 32'(q_o), 32'hE0E);

        repeat (4) @(negedge wr_clk);
        finish_run();
    end
endmodule